// File: doc/BRIEF.md
# Dual-Channel Wiper Register Bank with One-Hot Tap Decode

This block holds the digital control state of two digitally controlled potentiometer channels. Each channel owns one live wiper register and four preset registers. A serial front end, not part of this block, parses bus traffic and hands over already decoded commands. Each command is a single-cycle strobe that carries a channel index, a preset index, an opcode and an 8-bit data byte.

The host can write or read the wiper and every preset. It can also copy a chosen preset into the wiper. The low six bits of each wiper drive a 64-line switch-enable bus. Exactly one tap of the 64 points on the 63-segment resistor string is closed at every moment. Read results come back registered, one cycle after the command, together with a valid flag.

The command is sampled on the rising clock edge. Every state change, and the tap enable that follows from it, is visible right after that edge.

Top module: `wiperBank`

## Requirements
- R1: While `rstN` is low, and after it is released, every wiper and preset is zero, each channel enables tap 0 (bit 0 of its 64-bit slice), and `rdValid` is low.
- R2: In every cycle out of reset, each channel's 64-bit slice of `tapEn` has exactly one bit set. Channel c owns bits `64*c+63 .. 64*c`.
- R3: Opcode 2 (write wiper) loads bits 5..0 of `cmdData` into the selected channel's wiper. After that edge, only bit `cmdData[5:0]` of the channel's slice is set. Bits 7..6 of `cmdData` have no effect.
- R4: Opcode 0 (read wiper) returns the selected channel's wiper on `rdData` after the next edge, zero-extended so that bits 7..6 read as zero.
- R5: Opcode 3 (write preset) stores all 8 bits of `cmdData` into preset `cmdReg` of the selected channel. Opcode 1 (read preset) returns that byte unchanged on `rdData` after the next edge.
- R6: Opcode 4 (transfer) loads bits 5..0 of preset `cmdReg` into the selected channel's wiper. The tap enable moves on the same edge, and the preset keeps its value.
- R7: A command addressed to one channel leaves the other channel's wiper, presets and tap enable unchanged.
- R8: `rdValid` is high for exactly the one cycle that follows an accepted read, and low otherwise. Reads change no register.
- R9: A command with `cmdValid` low, or with opcode 5, 6 or 7, changes no register, leaves `tapEn` unchanged, and does not raise `rdValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdChan | input | 1 | Channel index |
| cmdReg | input | 2 | Preset index for preset read, write and transfer |
| cmdOp | input | 3 | Opcode: 0 read wiper, 1 read preset, 2 write wiper, 3 write preset, 4 transfer, 5 to 7 ignored |
| cmdData | input | 8 | Write data |
| rdData | output | 8 | Registered read result |
| rdValid | output | 1 | High for one cycle when `rdData` carries a result |
| tapEn | output | 128 | One-hot tap enables; channel 0 in bits 63..0, channel 1 in bits 127..64 |

## Verification
The assertions assume that the front end holds `cmdChan`, `cmdOp` and `cmdData` at known values whenever `cmdValid` is high. They also assume that `rstN` is low from time zero, so that the registers are defined before the one-hot and read-timing properties are evaluated. The stimulus drives every command input at the falling edge from a known idle value, and it raises the strobe for exactly one cycle per command. It keeps reset asserted over the first several edges. Within those limits the bench sweeps all 64 tap values on both channels with arbitrary upper data bits, writes and reads back every preset, transfers each preset, and issues the reserved opcodes.

// File: rtl/wiperBankPkg.sv
package wiperBankPkg;

  localparam int NUM_CH     = 2;
  localparam int NUM_PRESET = 4;
  localparam int DATA_W     = 8;
  localparam int TAP_BITS   = 6;
  localparam int OP_W       = 3;
  localparam int TAPS       = 1 << TAP_BITS;
  localparam int CHAN_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SEL_W      = (NUM_PRESET > 1) ? $clog2(NUM_PRESET) : 1;

  typedef enum logic [OP_W-1:0] {
    OP_RD_WIPER  = 3'd0,
    OP_RD_PRESET = 3'd1,
    OP_WR_WIPER  = 3'd2,
    OP_WR_PRESET = 3'd3,
    OP_XFER      = 3'd4
  } opE;

  typedef struct packed {
    logic              wrWiper;
    logic              wrPreset;
    logic              xfer;
    logic              rdWiper;
    logic              rdPreset;
    logic [CHAN_W-1:0] chan;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } strobeT;

endpackage

// File: rtl/wiperBankCtrl.sv
module wiperBankCtrl
  import wiperBankPkg::*;
(
  input  logic              cmdValid,
  input  logic [CHAN_W-1:0] cmdChan,
  input  logic [SEL_W-1:0]  cmdReg,
  input  logic [OP_W-1:0]   cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  output strobeT            strobes
);

  always_comb begin
    strobes          = '0;
    strobes.chan     = cmdChan;
    strobes.sel      = cmdReg;
    strobes.data     = cmdData;
    if (cmdValid) begin
      case (cmdOp)
        OP_RD_WIPER:  strobes.rdWiper  = 1'b1;
        OP_RD_PRESET: strobes.rdPreset = 1'b1;
        OP_WR_WIPER:  strobes.wrWiper  = 1'b1;
        OP_WR_PRESET: strobes.wrPreset = 1'b1;
        OP_XFER:      strobes.xfer     = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wiperBankData.sv
module wiperBankData
  import wiperBankPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     strobes,
  output logic [NUM_CH*TAP_BITS-1:0] wiperFlat,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdValid
);

  logic [TAP_BITS-1:0] wiperQ  [NUM_CH];
  logic [DATA_W-1:0]   presetQ [NUM_CH][NUM_PRESET];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        wiperQ[c] <= '0;
        for (int p = 0; p < NUM_PRESET; p++) presetQ[c][p] <= '0;
      end
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.rdWiper | strobes.rdPreset;
      if (strobes.rdWiper)
        rdData <= DATA_W'(wiperQ[strobes.chan]);
      else if (strobes.rdPreset)
        rdData <= presetQ[strobes.chan][strobes.sel];
      if (strobes.wrWiper)
        wiperQ[strobes.chan] <= strobes.data[TAP_BITS-1:0];
      else if (strobes.xfer)
        wiperQ[strobes.chan] <= presetQ[strobes.chan][strobes.sel][TAP_BITS-1:0];
      if (strobes.wrPreset)
        presetQ[strobes.chan][strobes.sel] <= strobes.data;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gFlat
    assign wiperFlat[c*TAP_BITS +: TAP_BITS] = wiperQ[c];
  end

endmodule

// File: rtl/tapDecoder.sv
module tapDecoder
  import wiperBankPkg::*;
(
  input  logic [TAP_BITS-1:0] tapSel,
  output logic [TAPS-1:0]     tapLines
);

  always_comb begin
    tapLines         = '0;
    tapLines[tapSel] = 1'b1;
  end

endmodule

// File: rtl/wiperBank.sv
module wiperBank
  import wiperBankPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [CHAN_W-1:0]      cmdChan,
  input  logic [SEL_W-1:0]       cmdReg,
  input  logic [OP_W-1:0]        cmdOp,
  input  logic [DATA_W-1:0]      cmdData,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid,
  output logic [NUM_CH*TAPS-1:0] tapEn
);

  strobeT                     strobes;
  logic [NUM_CH*TAP_BITS-1:0] wiperFlat;

  wiperBankCtrl ctrl_i (
    .cmdValid (cmdValid),
    .cmdChan  (cmdChan),
    .cmdReg   (cmdReg),
    .cmdOp    (cmdOp),
    .cmdData  (cmdData),
    .strobes  (strobes)
  );

  wiperBankData data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wiperFlat (wiperFlat),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : gDec
    tapDecoder dec_i (
      .tapSel   (wiperFlat[c*TAP_BITS +: TAP_BITS]),
      .tapLines (tapEn[c*TAPS +: TAPS])
    );
  end

endmodule

// File: rtl/wiperBankChk.sv
module wiperBankChk
  import wiperBankPkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   cmdValid,
  input logic [CHAN_W-1:0]      cmdChan,
  input logic [SEL_W-1:0]       cmdReg,
  input logic [OP_W-1:0]        cmdOp,
  input logic [DATA_W-1:0]      cmdData,
  input logic [DATA_W-1:0]      rdData,
  input logic                   rdValid,
  input logic [NUM_CH*TAPS-1:0] tapEn
);

  logic isRead;
  logic isWrite;
  logic isNop;
  assign isRead  = cmdValid && (cmdOp == OP_RD_WIPER || cmdOp == OP_RD_PRESET);
  assign isWrite = cmdValid && (cmdOp == OP_WR_WIPER || cmdOp == OP_WR_PRESET || cmdOp == OP_XFER);
  assign isNop   = !cmdValid || cmdOp > OP_XFER;

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    assert_one_hot_R2: assert property (@(posedge clk) disable iff (!rstN)
      $countones(tapEn[c*TAPS +: TAPS]) == 1);

    assert_wiper_write_R3: assert property (@(posedge clk) disable iff (!rstN)
      (cmdValid && cmdOp == OP_WR_WIPER && cmdChan == CHAN_W'(c))
      |=> tapEn[c*TAPS +: TAPS] == (TAPS'(1) << $past(cmdData[TAP_BITS-1:0])));

    assert_other_channel_R7: assert property (@(posedge clk) disable iff (!rstN)
      (isWrite && cmdChan != CHAN_W'(c)) |=> $stable(tapEn[c*TAPS +: TAPS]));
  end

  assert_wiper_read_upper_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_RD_WIPER) |=> rdData[DATA_W-1:TAP_BITS] == '0);

  assert_read_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    isRead |=> rdValid);

  assert_no_read_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> !rdValid);

  assert_nop_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    isNop |=> $stable(tapEn));

  always_comb begin
    if (!rstN) begin
      assert_reset_valid_R1: assert (rdValid == 1'b0);
    end
  end

endmodule

bind wiperBank wiperBankChk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdChan  (cmdChan),
  .cmdReg   (cmdReg),
  .cmdOp    (cmdOp),
  .cmdData  (cmdData),
  .rdData   (rdData),
  .rdValid  (rdValid),
  .tapEn    (tapEn)
);

// File: tb/wiperBank_tb_top.sv
`timescale 1ns/1ps
module wiperBank_tb_top;
  import wiperBankPkg::*;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   cmdValid = 1'b0;
  logic [CHAN_W-1:0]      cmdChan = '0;
  logic [SEL_W-1:0]       cmdReg = '0;
  logic [OP_W-1:0]        cmdOp = '0;
  logic [DATA_W-1:0]      cmdData = '0;
  logic [DATA_W-1:0]      rdData;
  logic                   rdValid;
  logic [NUM_CH*TAPS-1:0] tapEn;

  int compared = 0;
  int mismatched = 0;
  logic [5:0] mWiper [2];
  logic [7:0] mPreset [2][4];

  always #2.5 clk = ~clk;

  wiperBank dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdChan(cmdChan),
    .cmdReg(cmdReg), .cmdOp(cmdOp), .cmdData(cmdData),
    .rdData(rdData), .rdValid(rdValid), .tapEn(tapEn)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expTaps();
    logic [127:0] e;
    e = '0;
    e[{1'b0, mWiper[0]}] = 1'b1;
    e[64 + int'(mWiper[1])] = 1'b1;
    return e;
  endfunction

  task automatic doCmd(input logic [2:0] op, input int ch, input int sel, input logic [7:0] d,
                       input logic valid = 1'b1);
    @(negedge clk);
    cmdValid = valid; cmdOp = op; cmdChan = ch[0]; cmdReg = sel[1:0]; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    if (valid) begin
      case (op)
        3'd2: mWiper[ch] = d[5:0];
        3'd3: mPreset[ch][sel] = d;
        3'd4: mWiper[ch] = mPreset[ch][sel][5:0];
        default: ;
      endcase
    end
  endtask

  task automatic readCheck(input logic [2:0] op, input int ch, input int sel, input string req);
    logic [7:0] exp;
    exp = (op == 3'd0) ? {2'b00, mWiper[ch]} : mPreset[ch][sel];
    doCmd(op, ch, sel, 8'hA5);
    check({req, " rdValid"}, 128'(rdValid), 128'(1));
    check({req, " rdData"}, 128'(rdData), 128'(exp));
  endtask

  task automatic finishUp();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishUp();
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      mWiper[c] = '0;
      for (int p = 0; p < 4; p++) mPreset[c][p] = '0;
    end
    repeat (4) @(negedge clk);
    check("R1 tapEn in reset", tapEn, expTaps());
    check("R1 rdValid in reset", 128'(rdValid), 128'(0));
    rstN = 1'b1;
    @(negedge clk);
    check("R1 tapEn after reset", tapEn, expTaps());
    for (int c = 0; c < 2; c++) begin
      readCheck(3'd0, c, 0, "R1 wiper reset");
      for (int p = 0; p < 4; p++) readCheck(3'd1, c, p, "R1 preset reset");
    end

    // R3 / R2 / R7: full tap sweep, arbitrary upper bits
    for (int c = 0; c < 2; c++) begin
      for (int t = 0; t < 64; t++) begin
        doCmd(3'd2, c, 0, {2'(t * 3 + c), 6'(t)});
        check("R3 R2 R7 tap after wiper write", tapEn, expTaps());
        if (t % 9 == 0) readCheck(3'd0, c, 0, "R4 wiper readback");
      end
    end

    // R8: rdValid single cycle, reads change nothing
    readCheck(3'd0, 1, 0, "R8 read");
    @(negedge clk);
    check("R8 rdValid drops", 128'(rdValid), 128'(0));
    check("R8 read leaves taps", tapEn, expTaps());

    // R5: presets full 8 bits
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 4; p++) begin
        doCmd(3'd3, c, p, 8'((c * 4 + p) * 37 + 200));
        check("R5 R7 preset write leaves taps", tapEn, expTaps());
        check("R8 no rdValid on write", 128'(rdValid), 128'(0));
      end
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 4; p++) readCheck(3'd1, c, p, "R5 preset readback");

    // R6: transfer each preset
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 4; p++) begin
        doCmd(3'd4, c, p, 8'h00);
        check("R6 R7 tap after transfer", tapEn, expTaps());
        readCheck(3'd0, c, 0, "R6 wiper after transfer");
        readCheck(3'd1, c, p, "R6 preset kept");
      end

    // R9: invalid opcodes and cmdValid low
    for (int op = 5; op < 8; op++) begin
      doCmd(3'(op), op & 1, op & 3, 8'h3F);
      check("R9 reserved opcode taps", tapEn, expTaps());
      check("R9 reserved opcode rdValid", 128'(rdValid), 128'(0));
    end
    doCmd(3'd2, 0, 0, 8'h2A, 1'b0);
    check("R9 idle write taps", tapEn, expTaps());
    doCmd(3'd3, 1, 2, 8'h11, 1'b0);
    doCmd(3'd0, 1, 0, 8'h00, 1'b0);
    check("R9 idle read rdValid", 128'(rdValid), 128'(0));
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 4; p++) readCheck(3'd1, c, p, "R9 presets intact");

    // R1 again: reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    for (int c = 0; c < 2; c++) begin
      mWiper[c] = '0;
      for (int p = 0; p < 4; p++) mPreset[c][p] = '0;
    end
    @(negedge clk);
    check("R1 re-reset taps", tapEn, expTaps());
    rstN = 1'b1;
    for (int p = 0; p < 4; p++) readCheck(3'd1, 1, p, "R1 re-reset presets");
    finishUp();
  end

endmodule